// File: doc/BRIEF.md
# Translation Permission and Miss Classifier

This block sits beside an address-translation lookup and decides, for one memory access at a time, whether the access must trap. Each access carries a class: an instruction fetch, a data load or store, or one of several cache-maintenance operations. The block also sees the privilege mode and the two translation-enable bits, one for data and one for instructions. It takes the lookup's hit indication and the attributes of the matched page: write permission, execute permission, guarded, and a user-defined write-trap bit called U0. It also takes the page's 4-bit zone number, a 32-bit zone protection word and a global enable for U0 traps.

Every zone has a 2-bit code in the protection word. The code can deny all user access, or override the page's write and execute bits, and it does this differently in user and privileged mode. The block samples one request per strobe. One clock later it returns a result-valid pulse with at most one of four flags set: data-storage fault, instruction-storage fault, data miss, or instruction miss. A miss always wins over a permission verdict.

Top module: `xlat_perm_check`

## Requirements
- R1: While `rst_n` is low, `rsp_valid` and all four flags are 0.
- R2: A request is sampled on the clock edge where `req_valid` is 1. `rsp_valid` is 1 exactly in the following cycle. All flags are 0 whenever `rsp_valid` is 0.
- R3: At most one of `rsp_dstor`, `rsp_istor`, `rsp_dmiss`, `rsp_imiss` is 1 in any cycle.
- R4: A fetch (class 0) raises nothing when `xlat_inst_en` is 0. Any other class raises nothing when `xlat_data_en` is 0.
- R5: With `look_hit` 0, a fetch raises `rsp_imiss`. Classes 1 to 7 raise `rsp_dmiss`. Permission attributes are then ignored.
- R6: The cache-touch class (8) never raises any flag, whether it misses or violates a permission.
- R7: In user mode (`req_user`=1), zone code 00 raises `rsp_dstor` for load (1), store (2), cache-zero (3), cache-flush/store (4) and instruction-cache invalidate (7). It raises `rsp_istor` for a fetch. It does not affect cache invalidate (5) or congruence invalidate (6).
- R8: In user mode, a page with `pg_wr`=0 faults (`rsp_dstor`) on store and cache-zero unless its zone code is 11. A page with `pg_ex`=0 faults (`rsp_istor`) on fetch unless its zone code is 11.
- R9: In privileged mode, zone code 00 denies nothing. A page with `pg_wr`=0 faults on store, cache-zero, cache invalidate and congruence invalidate unless the zone code is 10 or 11. A page with `pg_ex`=0 faults on fetch under the same condition.
- R10: With `pg_u0`=1 and `u0_trap_en`=1, store and cache-zero raise `rsp_dstor` in both modes, whatever the zone code. In privileged mode, cache invalidate and congruence invalidate also fault.
- R11: A fetch that hits a page with `pg_grd`=1 raises `rsp_istor` in both modes, whatever the zone code.
- R12: Zone n uses bits [31-2n : 30-2n] of `zone_prot`, so zone 0 is the most significant pair.
- R13: Class codes 9 to 15 raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs sampled when high |
| req_cls | input | 4 | Access class: 0 fetch, 1 load, 2 store, 3 cache-zero, 4 cache-flush/store, 5 cache invalidate, 6 congruence invalidate, 7 instruction-cache invalidate, 8 cache-touch |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| xlat_data_en | input | 1 | Data translation enabled |
| xlat_inst_en | input | 1 | Instruction translation enabled |
| look_hit | input | 1 | Lookup found a valid matching entry |
| pg_wr | input | 1 | Page write permitted |
| pg_ex | input | 1 | Page execute permitted |
| pg_grd | input | 1 | Page guarded |
| pg_u0 | input | 1 | Page U0 write-trap attribute |
| pg_zone | input | 4 | Zone number of matched page |
| zone_prot | input | 32 | Sixteen 2-bit zone codes |
| u0_trap_en | input | 1 | Enables U0 write traps |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_dstor | output | 1 | Data-storage fault |
| rsp_istor | output | 1 | Instruction-storage fault |
| rsp_dmiss | output | 1 | Data translation miss |
| rsp_imiss | output | 1 | Instruction translation miss |

## Verification
The bench probes the places where the two modes part ways. In user mode, zone 10 gives no write override, while in privileged mode it does. A design that treats the modes alike lets user stores through or blocks privileged ones. The bench also checks that cache invalidate and congruence invalidate fault only in privileged mode, and that cache-touch stays silent on both misses and faults. It checks that a miss hides the permission bits, so a design that evaluates permissions first reports a storage fault where a miss is due. Guarded fetches are driven under override zone codes, and single-zone protection words expose a reversed zone bit order.

// File: rtl/xlat_perm_pkg.sv
package xlat_perm_pkg;

  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_FETCH  = 4'd0,
    CLS_LOAD   = 4'd1,
    CLS_STORE  = 4'd2,
    CLS_CZERO  = 4'd3,
    CLS_CFLUSH = 4'd4,
    CLS_CINV   = 4'd5,
    CLS_CCINV  = 4'd6,
    CLS_ICINV  = 4'd7,
    CLS_CTOUCH = 4'd8
  } acc_cls_e;

  typedef struct packed {
    logic dstor;
    logic istor;
    logic dmiss;
    logic imiss;
  } exc_flags_t;

  localparam logic [1:0] ZC_DENY  = 2'b00;
  localparam logic [1:0] ZC_ALL   = 2'b11;

endpackage

// File: rtl/xlat_zone_sel.sv
module xlat_zone_sel #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned NUM_ZONES = 1 << IDX_W,
  localparam int unsigned ZPR_W = 2 * NUM_ZONES
) (
  input  logic [ZPR_W-1:0] zone_prot,
  input  logic [IDX_W-1:0] zone_idx,
  output logic [1:0]       zone_code
);

  logic [1:0] codes [NUM_ZONES];

  // Zone 0 occupies the most significant bit pair.
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign codes[z] = zone_prot[ZPR_W-1-2*z -: 2];
  end

  assign zone_code = codes[zone_idx];

endmodule

// File: rtl/xlat_data_eval.sv
module xlat_data_eval
  import xlat_perm_pkg::*;
(
  input  acc_cls_e   cls,
  input  logic       user,
  input  logic       xlat_en,
  input  logic       hit,
  input  logic       wr_ok,
  input  logic       u0,
  input  logic       u0_en,
  input  logic [1:0] zcode,
  output logic       stor,
  output logic       miss
);

  logic data_cls, touch, zone_set, user_wr_set, priv_wr_set, wr_set;
  logic zone_deny, wr_override, wp_fault, u0_fault, active;

  always_comb begin
    data_cls = (cls != CLS_FETCH) && (cls <= CLS_CTOUCH);
    touch    = (cls == CLS_CTOUCH);

    zone_set    = (cls == CLS_LOAD)  || (cls == CLS_STORE) ||
                  (cls == CLS_CZERO) || (cls == CLS_CFLUSH) ||
                  (cls == CLS_ICINV);
    user_wr_set = (cls == CLS_STORE) || (cls == CLS_CZERO);
    priv_wr_set = user_wr_set || (cls == CLS_CINV) || (cls == CLS_CCINV);
    wr_set      = user ? user_wr_set : priv_wr_set;

    zone_deny   = user && (zcode == ZC_DENY) && zone_set;
    wr_override = user ? (zcode == ZC_ALL) : zcode[1];
    wp_fault    = wr_set && !wr_ok && !wr_override;
    u0_fault    = wr_set && u0 && u0_en;

    active = xlat_en && data_cls && !touch;
    miss   = active && !hit;
    stor   = active && hit && (zone_deny || wp_fault || u0_fault);
  end

endmodule

// File: rtl/xlat_inst_eval.sv
module xlat_inst_eval
  import xlat_perm_pkg::*;
(
  input  acc_cls_e   cls,
  input  logic       user,
  input  logic       xlat_en,
  input  logic       hit,
  input  logic       ex_ok,
  input  logic       guarded,
  input  logic [1:0] zcode,
  output logic       stor,
  output logic       miss
);

  logic active, zone_deny, ex_override, ex_fault;

  always_comb begin
    active      = xlat_en && (cls == CLS_FETCH);
    zone_deny   = user && (zcode == ZC_DENY);
    ex_override = user ? (zcode == ZC_ALL) : zcode[1];
    ex_fault    = !ex_ok && !ex_override;
    miss        = active && !hit;
    stor        = active && hit && (zone_deny || ex_fault || guarded);
  end

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_perm_pkg::*;
#(
  parameter int unsigned ZIDX_W = 4,
  localparam int unsigned ZPR_W = 2 * (1 << ZIDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CLS_W-1:0]  req_cls,
  input  logic              req_user,
  input  logic              xlat_data_en,
  input  logic              xlat_inst_en,
  input  logic              look_hit,
  input  logic              pg_wr,
  input  logic              pg_ex,
  input  logic              pg_grd,
  input  logic              pg_u0,
  input  logic [ZIDX_W-1:0] pg_zone,
  input  logic [ZPR_W-1:0]  zone_prot,
  input  logic              u0_trap_en,
  output logic              rsp_valid,
  output logic              rsp_dstor,
  output logic              rsp_istor,
  output logic              rsp_dmiss,
  output logic              rsp_imiss
);

  acc_cls_e   cls;
  logic [1:0] zcode;
  logic       d_stor, d_miss, i_stor, i_miss;
  exc_flags_t flags_d, flags_q;
  logic       valid_d, valid_q, reg_en;

  assign cls = acc_cls_e'(req_cls);

  xlat_zone_sel #(.IDX_W(ZIDX_W)) zone_sel_i (
    .zone_prot (zone_prot),
    .zone_idx  (pg_zone),
    .zone_code (zcode)
  );

  xlat_data_eval data_eval_i (
    .cls     (cls),
    .user    (req_user),
    .xlat_en (xlat_data_en),
    .hit     (look_hit),
    .wr_ok   (pg_wr),
    .u0      (pg_u0),
    .u0_en   (u0_trap_en),
    .zcode   (zcode),
    .stor    (d_stor),
    .miss    (d_miss)
  );

  xlat_inst_eval inst_eval_i (
    .cls     (cls),
    .user    (req_user),
    .xlat_en (xlat_inst_en),
    .hit     (look_hit),
    .ex_ok   (pg_ex),
    .guarded (pg_grd),
    .zcode   (zcode),
    .stor    (i_stor),
    .miss    (i_miss)
  );

  // Next state: flags only alongside a sampled request.
  always_comb begin
    valid_d = req_valid;
    flags_d = '0;
    if (req_valid) begin
      flags_d.dstor = d_stor;
      flags_d.istor = i_stor;
      flags_d.dmiss = d_miss;
      flags_d.imiss = i_miss;
    end
    reg_en = req_valid || valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (reg_en) begin
      valid_q <= valid_d;
      flags_q <= flags_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_dstor = flags_q.dstor;
  assign rsp_istor = flags_q.istor;
  assign rsp_dmiss = flags_q.dmiss;
  assign rsp_imiss = flags_q.imiss;

endmodule

// File: rtl/xlat_perm_check_sva.sv
module xlat_perm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_cls,
  input logic       xlat_data_en,
  input logic       xlat_inst_en,
  input logic       look_hit,
  input logic       pg_grd,
  input logic       rsp_valid,
  input logic       rsp_dstor,
  input logic       rsp_istor,
  input logic       rsp_dmiss,
  input logic       rsp_imiss
);

  logic [3:0] fl;
  assign fl = {rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss};

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (rsp_valid == 1'b0 && fl == 4'b0);
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (fl == 4'b0));

  assert_one_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl));

  assert_data_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_data_en && req_cls != 4'd0) |=> (!rsp_dstor && !rsp_dmiss));

  assert_inst_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xlat_inst_en && req_cls == 4'd0) |=> (!rsp_istor && !rsp_imiss));

  assert_store_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_data_en && !look_hit && req_cls == 4'd2) |=> rsp_dmiss);

  assert_fetch_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_inst_en && !look_hit && req_cls == 4'd0) |=> rsp_imiss);

  assert_touch_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cls == 4'd8) |=> (fl == 4'b0));

  assert_guarded_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlat_inst_en && look_hit && pg_grd && req_cls == 4'd0) |=> rsp_istor);

  assert_reserved_cls_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cls > 4'd8) |=> (fl == 4'b0));

endmodule

bind xlat_perm_check xlat_perm_check_sva chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_cls      (req_cls),
  .xlat_data_en (xlat_data_en),
  .xlat_inst_en (xlat_inst_en),
  .look_hit     (look_hit),
  .pg_grd       (pg_grd),
  .rsp_valid    (rsp_valid),
  .rsp_dstor    (rsp_dstor),
  .rsp_istor    (rsp_istor),
  .rsp_dmiss    (rsp_dmiss),
  .rsp_imiss    (rsp_imiss)
);

// File: tb/xlat_perm_check_tb_top.sv
`timescale 1ns/1ps
module xlat_perm_check_tb_top;

  typedef struct {
    logic [3:0]  cls;
    logic        user, den, ien, hit, wr, ex, grd, u0, u0en;
    logic [3:0]  zone;
    logic [31:0] zpr;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_cls = '0;
  logic req_user = 1'b0, xlat_data_en = 1'b0, xlat_inst_en = 1'b0, look_hit = 1'b0;
  logic pg_wr = 1'b0, pg_ex = 1'b0, pg_grd = 1'b0, pg_u0 = 1'b0, u0_trap_en = 1'b0;
  logic [3:0] pg_zone = '0;
  logic [31:0] zone_prot = '0;
  logic rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xlat_perm_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
    .req_user(req_user), .xlat_data_en(xlat_data_en), .xlat_inst_en(xlat_inst_en),
    .look_hit(look_hit), .pg_wr(pg_wr), .pg_ex(pg_ex), .pg_grd(pg_grd),
    .pg_u0(pg_u0), .pg_zone(pg_zone), .zone_prot(zone_prot), .u0_trap_en(u0_trap_en),
    .rsp_valid(rsp_valid), .rsp_dstor(rsp_dstor), .rsp_istor(rsp_istor),
    .rsp_dmiss(rsp_dmiss), .rsp_imiss(rsp_imiss)
  );

  // Reference model built from the rule list: {dstor, istor, dmiss, imiss}.
  function automatic logic [3:0] model(stim_t s);
    logic [1:0] zc;
    logic store_like, priv_extra, zone_list, writing;
    zc = s.zpr[31 - 2*s.zone -: 2];
    if (s.cls == 4'd0) begin
      if (!s.ien) return 4'b0000;
      if (!s.hit) return 4'b0001;
      if (s.grd) return 4'b0100;
      if (s.user && zc == 2'b00) return 4'b0100;
      if (!s.ex && s.user && zc != 2'b11) return 4'b0100;
      if (!s.ex && !s.user && zc != 2'b10 && zc != 2'b11) return 4'b0100;
      return 4'b0000;
    end
    if (s.cls >= 4'd8) return 4'b0000;
    if (!s.den) return 4'b0000;
    if (!s.hit) return 4'b0010;
    store_like = (s.cls == 4'd2) || (s.cls == 4'd3);
    priv_extra = (s.cls == 4'd5) || (s.cls == 4'd6);
    zone_list  = (s.cls == 4'd1) || store_like || (s.cls == 4'd4) || (s.cls == 4'd7);
    if (s.user) begin
      if (zc == 2'b00 && zone_list) return 4'b1000;
      writing = store_like;
      if (writing && !s.wr && zc != 2'b11) return 4'b1000;
    end else begin
      writing = store_like || priv_extra;
      if (writing && !s.wr && zc[1] == 1'b0) return 4'b1000;
    end
    if (writing && s.u0 && s.u0en) return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic stim_t base();
    stim_t s;
    s.cls = 4'd1; s.user = 1'b1; s.den = 1'b1; s.ien = 1'b1; s.hit = 1'b1;
    s.wr = 1'b1; s.ex = 1'b1; s.grd = 1'b0; s.u0 = 1'b0; s.u0en = 1'b0;
    s.zone = 4'd3; s.zpr = 32'h5555_5555;
    return s;
  endfunction

  function automatic logic [31:0] zpr_with(logic [3:0] z, logic [1:0] code);
    logic [31:0] v;
    v = 32'h5555_5555;
    v[31 - 2*z -: 2] = code;
    return v;
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got valid/flags=%b expected=%b", tag, got, exp);
    end
  endtask

  // Called at a falling edge; drives, waits one cycle, checks.
  task automatic run(string tag, stim_t s, logic [3:0] exp);
    req_valid = 1'b1; req_cls = s.cls; req_user = s.user;
    xlat_data_en = s.den; xlat_inst_en = s.ien; look_hit = s.hit;
    pg_wr = s.wr; pg_ex = s.ex; pg_grd = s.grd; pg_u0 = s.u0;
    u0_trap_en = s.u0en; pg_zone = s.zone; zone_prot = s.zpr;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, {rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss}, {1'b1, exp});
    if (exp !== model(s)) begin
      checks++; failures++;
      $display("FAIL %s bench table mismatch got=%b expected=%b", tag, model(s), exp);
    end
  endtask

  initial begin
    stim_t s;
    logic [3:0] e;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset", {rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss}, 5'b0);

    s = base(); run("R2 plain load", s, 4'b0000);
    @(negedge clk);
    check("R2 idle cycle", {rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss}, 5'b0);

    s = base(); s.cls = 4'd2; s.hit = 0; s.den = 0; run("R4 data off", s, 4'b0000);
    s = base(); s.cls = 4'd0; s.hit = 0; s.ien = 0; run("R4 inst off", s, 4'b0000);
    s = base(); s.cls = 4'd0; s.hit = 0; s.den = 0; run("R4 fetch with data off", s, 4'b0001);

    s = base(); s.cls = 4'd2; s.hit = 0; s.wr = 0; s.zpr = 32'h0; run("R5 store miss wins", s, 4'b0010);
    s = base(); s.cls = 4'd0; s.hit = 0; s.grd = 1; run("R5 fetch miss wins", s, 4'b0001);
    s = base(); s.cls = 4'd7; s.hit = 0; run("R5 icinv miss", s, 4'b0010);

    s = base(); s.cls = 4'd8; s.hit = 0; run("R6 touch miss", s, 4'b0000);
    s = base(); s.cls = 4'd8; s.zpr = 32'h0; s.wr = 0; run("R6 touch zone deny", s, 4'b0000);

    s = base(); s.zpr = 32'h0; run("R7 user load zone00", s, 4'b1000);
    s = base(); s.cls = 4'd7; s.zpr = 32'h0; run("R7 user icinv zone00", s, 4'b1000);
    s = base(); s.cls = 4'd5; s.zpr = 32'h0; run("R7 user cinv zone00", s, 4'b0000);
    s = base(); s.cls = 4'd0; s.zpr = 32'h0; run("R7 user fetch zone00", s, 4'b0100);

    s = base(); s.cls = 4'd2; s.wr = 0; s.zpr = 32'hAAAA_AAAA; run("R8 user store zone10", s, 4'b1000);
    s = base(); s.cls = 4'd3; s.wr = 0; s.zpr = 32'hFFFF_FFFF; run("R8 user czero zone11", s, 4'b0000);
    s = base(); s.cls = 4'd0; s.ex = 0; s.zpr = 32'hFFFF_FFFF; run("R8 user fetch zone11", s, 4'b0000);
    s = base(); s.cls = 4'd0; s.ex = 0; s.zpr = 32'hAAAA_AAAA; run("R8 user fetch zone10", s, 4'b0100);

    s = base(); s.user = 0; s.zpr = 32'h0; run("R9 priv load zone00", s, 4'b0000);
    s = base(); s.user = 0; s.cls = 4'd2; s.wr = 0; s.zpr = 32'hAAAA_AAAA; run("R9 priv store zone10", s, 4'b0000);
    s = base(); s.user = 0; s.cls = 4'd2; s.wr = 0; run("R9 priv store zone01", s, 4'b1000);
    s = base(); s.user = 0; s.cls = 4'd6; s.wr = 0; run("R9 priv ccinv zone01", s, 4'b1000);
    s = base(); s.cls = 4'd6; s.wr = 0; run("R9 user ccinv not checked", s, 4'b0000);
    s = base(); s.user = 0; s.cls = 4'd0; s.ex = 0; s.zpr = 32'h0; run("R9 priv fetch zone00", s, 4'b0100);

    s = base(); s.cls = 4'd2; s.u0 = 1; s.u0en = 1; s.zpr = 32'hFFFF_FFFF; run("R10 user u0 store", s, 4'b1000);
    s = base(); s.cls = 4'd2; s.u0 = 1; s.u0en = 0; s.zpr = 32'hFFFF_FFFF; run("R10 u0 disabled", s, 4'b0000);
    s = base(); s.user = 0; s.cls = 4'd5; s.u0 = 1; s.u0en = 1; s.zpr = 32'hFFFF_FFFF; run("R10 priv u0 cinv", s, 4'b1000);
    s = base(); s.cls = 4'd5; s.u0 = 1; s.u0en = 1; run("R10 user u0 cinv", s, 4'b0000);
    s = base(); s.cls = 4'd1; s.u0 = 1; s.u0en = 1; run("R10 u0 load", s, 4'b0000);

    s = base(); s.user = 0; s.cls = 4'd0; s.grd = 1; s.zpr = 32'hFFFF_FFFF; run("R11 priv guarded", s, 4'b0100);
    s = base(); s.cls = 4'd0; s.grd = 1; s.zpr = 32'hFFFF_FFFF; run("R11 user guarded", s, 4'b0100);

    s = base(); s.zone = 4'd5; s.zpr = zpr_with(4'd5, 2'b00); run("R12 zone5 selected", s, 4'b1000);
    s = base(); s.zone = 4'd4; s.zpr = zpr_with(4'd5, 2'b00); run("R12 zone4 neighbour", s, 4'b0000);
    s = base(); s.zone = 4'd0; s.zpr = zpr_with(4'd0, 2'b00); run("R12 zone0 msb", s, 4'b1000);
    s = base(); s.zone = 4'd15; s.zpr = zpr_with(4'd15, 2'b00); run("R12 zone15 lsb", s, 4'b1000);

    s = base(); s.cls = 4'd12; s.hit = 0; run("R13 reserved class", s, 4'b0000);

    for (int i = 0; i < 3000; i++) begin
      s.cls = 4'($urandom_range(0, 9)); s.user = 1'($urandom); s.den = 1'($urandom);
      s.ien = 1'($urandom); s.hit = ($urandom_range(0, 7) != 0); s.wr = 1'($urandom);
      s.ex = 1'($urandom); s.grd = ($urandom_range(0, 3) == 0); s.u0 = 1'($urandom);
      s.u0en = 1'($urandom); s.zone = 4'($urandom); s.zpr = $urandom;
      e = model(s);
      run("R3 random mix", s, e);
      if ($urandom_range(0, 4) == 0) begin
        @(negedge clk);
        check("R2 random gap", {rsp_valid, rsp_dstor, rsp_istor, rsp_dmiss, rsp_imiss}, 5'b0);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule